// File: doc/BRIEF.md
# Device IN Endpoint Transmit Path

This block feeds the transmit side of a device controller for IN transfers. Each IN endpoint owns its own packet buffer. Software announces a packet with a byte count and then writes its bytes, all through a single valid/ready write port. When a token for an endpoint arrives from the token decoder, the block streams that endpoint's bytes to the serializer, then appends a CRC16 of two bytes. A token for an endpoint that holds no packet produces a NAK request and no data.

Endpoints may be served in any order. Transmission may begin before software has written the whole packet. If the transmitter catches up with the write side, it cuts the packet short and ends it with the uncomplemented CRC register, so the far end sees a bad CRC and drops the packet. After the packet, the block waits for the handshake outcome. An ACK frees the buffer and flips the endpoint's DATA0/DATA1 toggle. A timeout keeps the packet and the toggle for a retry. Either outcome raises a one-cycle completion pulse for the endpoint, together with the outcome.

Top module: `usb_in_txpath`

## Requirements
- R1: After reset, no byte is offered (`tx_valid`=0), no completion or NAK pulse is raised, every endpoint is free and every toggle is DATA0 (`tx_data1`=0 on the first packet).
- R2: A write beat with `ld_hdr`=1 carries the byte count in `ld_data` (0 to 64). It is accepted only if that endpoint holds no packet and the count is at most 64. A beat with `ld_hdr`=0 carries one data byte. It is accepted only while the endpoint holds a packet with fewer bytes written than its count. Otherwise `ld_ready` is 0 and the beat has no effect.
- R3: A token for an endpoint with no packet raises `nak_pulse` for one cycle, on the cycle after the token, and offers no byte.
- R4: A token for a loaded endpoint streams its bytes in write order, then the CRC low byte, then the CRC high byte, with `tx_last` on the final byte. The CRC is the ones' complement of a 16-bit register. The register starts at FFFF and processes each byte LSB first with the reflected polynomial A001 (x^16+x^15+x^2+1).
- R5: A zero-length packet is sent as the two CRC bytes 00 00.
- R6: If the next byte to send has not yet been written, no further data is sent. The two trailing bytes are then the CRC register itself, not its complement, computed over the bytes already sent.
- R7: Packets held in different endpoints do not interfere, and they can be requested in any order.
- R8: `tx_data1` gives the endpoint's toggle for the whole packet. An ACK handshake (`hs_valid`=1, `hs_ack`=1) flips the toggle and frees the buffer. One cycle later, `done_irq` has exactly the endpoint's bit set and `done_ack`=1.
- R9: A timeout (`hs_valid`=1, `hs_ack`=0) keeps the packet and the toggle. It raises `done_irq` for the endpoint with `done_ack`=0. A later token sends the same bytes again.
- R10: A token that arrives while a packet is being sent or is awaiting its handshake is ignored (no NAK, no restart). A handshake that arrives while no packet is awaiting one is ignored (no `done_irq`).
- R11: While `tx_valid`=1 and `tx_ready`=0, `tx_valid`, `tx_data` and `tx_last` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Write beat valid |
| ld_ready | output | 1 | Write beat accepted this cycle |
| ld_ep | input | EPW | Endpoint addressed by the write beat |
| ld_hdr | input | 1 | 1: beat carries a byte count; 0: beat carries a data byte |
| ld_data | input | 8 | Byte count or data byte |
| tok_valid | input | 1 | IN token pulse from the token decoder |
| tok_ep | input | EPW | Endpoint named by the token |
| nak_pulse | output | 1 | Request to answer the token with NAK |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Byte on offer |
| tx_last | output | 1 | Byte on offer is the final CRC byte |
| tx_data1 | output | 1 | Packet goes out as DATA1 (1) or DATA0 (0) |
| hs_valid | input | 1 | Handshake outcome valid |
| hs_ack | input | 1 | 1: ACK received; 0: timeout |
| done_irq | output | NEP | Per-endpoint completion pulse |
| done_ack | output | 1 | Outcome that goes with `done_irq` |

## Verification
A sweep over every packet length from 0 to 64 rotates through the endpoints and three serializer-ready patterns. Always-ready, regular-gap and bursty stalls separate correct byte ordering and CRC folding from hold-on-stall errors. The same sweep follows each endpoint's toggle from one acknowledged packet to the next. Loading several endpoints and serving them out of order tells dedicated buffers apart from shared or queued ones. Partial writes before a token (including none at all) are set against complete packets to tell the corrupt trailer apart from the good one. A timeout followed by a retry shows that the held packet and its toggle survive. Tokens and handshakes sent in the wrong phase, and rejected write beats, are checked at the ports for having no effect.

// File: rtl/usbin_pkg.sv
package usbin_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_SEND,
    S_CRCLO,
    S_CRCHI,
    S_WAIT
  } tx_state_t;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // fold one byte, least significant bit first, into the reflected CRC16 register
  function automatic logic [15:0] crc16_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/ep_buf_mem.sv
module ep_buf_mem #(
  parameter int NEP   = 4,
  parameter int DEPTH = 64,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam int WORDS = NEP * DEPTH;

  // one region of DEPTH bytes per endpoint; simple dual port for block RAM
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/ep_ctx.sv
module ep_ctx #(
  parameter int NEP   = 4,
  parameter int DEPTH = 64,
  parameter int EPW   = 2,
  parameter int LW    = 7,
  parameter int AW    = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid,
  input  logic           ld_hdr,
  input  logic [EPW-1:0] ld_ep,
  input  logic [7:0]     ld_data,
  output logic           ld_ready,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  input  logic [EPW-1:0] sel_ep,
  output logic           sel_armed,
  output logic [LW-1:0]  sel_len,
  output logic [LW-1:0]  sel_fill,
  output logic           sel_tog,
  input  logic           rel_en,
  input  logic [EPW-1:0] rel_ep
);

  logic [NEP-1:0] armed_q;
  logic [NEP-1:0] tog_q;
  logic [LW-1:0]  len_q  [NEP];
  logic [LW-1:0]  fill_q [NEP];

  logic hdr_ok, dat_ok, rel_clash, take;

  always_comb begin
    rel_clash = rel_en && (rel_ep == ld_ep);
    hdr_ok    = !armed_q[ld_ep] && (ld_data <= 8'(DEPTH));
    dat_ok    = armed_q[ld_ep] && (fill_q[ld_ep] < len_q[ld_ep]);
    ld_ready  = !rel_clash && (ld_hdr ? hdr_ok : dat_ok);
    take      = ld_valid && ld_ready;
    wr_en     = take && !ld_hdr;
    wr_addr   = AW'(int'(ld_ep) * DEPTH + int'(fill_q[ld_ep]));
  end

  assign sel_armed = armed_q[sel_ep];
  assign sel_len   = len_q[sel_ep];
  assign sel_fill  = fill_q[sel_ep];
  assign sel_tog   = tog_q[sel_ep];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= '0;
      tog_q   <= '0;
      for (int e = 0; e < NEP; e++) begin
        len_q[e]  <= '0;
        fill_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NEP; e++) begin
        if (rel_en && rel_ep == EPW'(e)) begin
          armed_q[e] <= 1'b0;
          fill_q[e]  <= '0;
          tog_q[e]   <= ~tog_q[e];
        end else if (take && ld_ep == EPW'(e)) begin
          if (ld_hdr) begin
            armed_q[e] <= 1'b1;
            len_q[e]   <= ld_data[LW-1:0];
            fill_q[e]  <= '0;
          end else begin
            fill_q[e] <= fill_q[e] + 1'b1;
          end
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NEP; g++) begin : g_chk
      // R2: never more bytes written than the announced count
      p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
        fill_q[g] <= len_q[g]);
    end
  endgenerate

  // R2: an accepted count beat leaves the endpoint holding a packet
  p_hdr_arms_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && ld_hdr) |=> armed_q[$past(ld_ep)]);

endmodule

// File: rtl/tx_engine.sv
module tx_engine
  import usbin_pkg::*;
#(
  parameter int NEP   = 4,
  parameter int DEPTH = 64,
  parameter int EPW   = 2,
  parameter int LW    = 7,
  parameter int AW    = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tok_valid,
  input  logic [EPW-1:0] tok_ep,
  output logic [EPW-1:0] sel_ep,
  input  logic           sel_armed,
  input  logic [LW-1:0]  sel_len,
  input  logic [LW-1:0]  sel_fill,
  input  logic           sel_tog,
  output logic [AW-1:0]  rd_addr,
  input  logic [7:0]     rd_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  output logic           tx_data1,
  input  logic           hs_valid,
  input  logic           hs_ack,
  output logic           rel_en,
  output logic [EPW-1:0] rel_ep,
  output logic [NEP-1:0] done_irq,
  output logic           done_ack,
  output logic           nak_pulse
);

  tx_state_t      st;
  logic [EPW-1:0] cur_ep;
  logic [LW-1:0]  idx;
  logic [15:0]    crc;
  logic           bad;
  logic           at_end, dry;

  assign sel_ep  = (st == S_IDLE) ? tok_ep : cur_ep;
  assign rd_addr = AW'(int'(cur_ep) * DEPTH + int'(idx));
  assign rel_en  = (st == S_WAIT) && hs_valid && hs_ack;
  assign rel_ep  = cur_ep;
  assign at_end  = (idx == sel_len);
  assign dry     = (idx >= sel_fill);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur_ep    <= '0;
      idx       <= '0;
      crc       <= CRC_SEED;
      bad       <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_last   <= 1'b0;
      tx_data1  <= 1'b0;
      done_irq  <= '0;
      done_ack  <= 1'b0;
      nak_pulse <= 1'b0;
    end else begin
      nak_pulse <= 1'b0;
      done_irq  <= '0;
      case (st)
        S_IDLE: begin
          if (tok_valid) begin
            if (sel_armed) begin
              cur_ep   <= tok_ep;
              idx      <= '0;
              crc      <= CRC_SEED;
              bad      <= 1'b0;
              tx_data1 <= sel_tog;
              st       <= S_FETCH;
            end else begin
              nak_pulse <= 1'b1;
            end
          end
        end
        S_FETCH: begin
          if (at_end || dry) begin
            // a short packet ends with the raw register so the receiver rejects it
            bad      <= !at_end;
            tx_data  <= at_end ? ~crc[7:0] : crc[7:0];
            tx_valid <= 1'b1;
            st       <= S_CRCLO;
          end else begin
            st <= S_LOAD;
          end
        end
        S_LOAD: begin
          tx_data  <= rd_data;
          tx_valid <= 1'b1;
          crc      <= crc16_upd(crc, rd_data);
          idx      <= idx + 1'b1;
          st       <= S_SEND;
        end
        S_SEND: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            st       <= S_FETCH;
          end
        end
        S_CRCLO: begin
          if (tx_ready) begin
            tx_data <= bad ? crc[15:8] : ~crc[15:8];
            tx_last <= 1'b1;
            st      <= S_CRCHI;
          end
        end
        S_CRCHI: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            st       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (hs_valid) begin
            done_irq[cur_ep] <= 1'b1;
            done_ack         <= hs_ack;
            st               <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: an offered byte waits unchanged for the serializer
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R3: a NAK request never coincides with data on offer
  p_nak_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    nak_pulse |-> !tx_valid);

  // R8: at most one endpoint completes per cycle
  p_irq_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_irq));

  // R10: a completion pulse always follows a handshake input
  p_irq_after_hs_r10: assert property (@(posedge clk) disable iff (rst)
    (|done_irq) |-> $past(hs_valid));

  // R4: the final marker only leaves with an offered byte
  p_last_valid_r4: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

endmodule

// File: rtl/usb_in_txpath.sv
module usb_in_txpath #(
  parameter int NEP   = 4,
  parameter int DEPTH = 64,
  parameter int EPW   = $clog2(NEP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic [EPW-1:0] ld_ep,
  input  logic           ld_hdr,
  input  logic [7:0]     ld_data,
  input  logic           tok_valid,
  input  logic [EPW-1:0] tok_ep,
  output logic           nak_pulse,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  output logic           tx_data1,
  input  logic           hs_valid,
  input  logic           hs_ack,
  output logic [NEP-1:0] done_irq,
  output logic           done_ack
);

  localparam int LW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(NEP * DEPTH);

  logic           wr_en;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [7:0]     rd_data;
  logic [EPW-1:0] sel_ep, rel_ep;
  logic           sel_armed, sel_tog, rel_en;
  logic [LW-1:0]  sel_len, sel_fill;

  ep_buf_mem #(.NEP(NEP), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (ld_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  ep_ctx #(.NEP(NEP), .DEPTH(DEPTH), .EPW(EPW), .LW(LW), .AW(AW)) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_hdr    (ld_hdr),
    .ld_ep     (ld_ep),
    .ld_data   (ld_data),
    .ld_ready  (ld_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .sel_ep    (sel_ep),
    .sel_armed (sel_armed),
    .sel_len   (sel_len),
    .sel_fill  (sel_fill),
    .sel_tog   (sel_tog),
    .rel_en    (rel_en),
    .rel_ep    (rel_ep)
  );

  tx_engine #(.NEP(NEP), .DEPTH(DEPTH), .EPW(EPW), .LW(LW), .AW(AW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_ep    (tok_ep),
    .sel_ep    (sel_ep),
    .sel_armed (sel_armed),
    .sel_len   (sel_len),
    .sel_fill  (sel_fill),
    .sel_tog   (sel_tog),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_data1  (tx_data1),
    .hs_valid  (hs_valid),
    .hs_ack    (hs_ack),
    .rel_en    (rel_en),
    .rel_ep    (rel_ep),
    .done_irq  (done_irq),
    .done_ack  (done_ack),
    .nak_pulse (nak_pulse)
  );

endmodule

// File: tb/test_usb_in_txpath.sv
`timescale 1ns/100ps
module test_usb_in_txpath;

  localparam int NEP = 4;
  localparam int DEPTH = 64;
  localparam int EPW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_valid = 1'b0;
  logic           ld_ready;
  logic [EPW-1:0] ld_ep = '0;
  logic           ld_hdr = 1'b0;
  logic [7:0]     ld_data = '0;
  logic           tok_valid = 1'b0;
  logic [EPW-1:0] tok_ep = '0;
  logic           nak_pulse;
  logic           tx_valid;
  logic           tx_ready = 1'b0;
  logic [7:0]     tx_data;
  logic           tx_last;
  logic           tx_data1;
  logic           hs_valid = 1'b0;
  logic           hs_ack = 1'b0;
  logic [NEP-1:0] done_irq;
  logic           done_ack;

  always #2.5 clk = ~clk;

  usb_in_txpath #(.NEP(NEP), .DEPTH(DEPTH)) i_usb_in_txpath (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_ep(ld_ep), .ld_hdr(ld_hdr), .ld_data(ld_data),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .nak_pulse(nak_pulse),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_data1(tx_data1),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .done_irq(done_irq), .done_ack(done_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit summary_done = 0;
  logic [7:0] got [80];
  int got_n;
  bit got_d1;
  bit exp_tog [NEP];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  function automatic logic [7:0] pat(input int ep, input int len, input int i);
    return 8'(ep * 53 + i * 29 + len * 7 + 1);
  endfunction

  function automatic logic [15:0] crc_of(input int ep, input int len, input int n);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      r = r ^ {8'h00, pat(ep, len, i)};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    return r;
  endfunction

  task automatic ld_beat(input int ep, input bit hdr, input int val, output bit acc);
    @(negedge clk);
    ld_valid = 1'b1; ld_ep = EPW'(ep); ld_hdr = hdr; ld_data = 8'(val);
    #1 acc = ld_ready;
    @(posedge clk);
    #1 ld_valid = 1'b0;
  endtask

  task automatic load_hdr(input int ep, input int len);
    bit a;
    ld_beat(ep, 1'b1, len, a);
    chk(a, "R2", "count beat accepted", a, 1);
  endtask

  task automatic write_bytes(input int ep, input int len, input int from, input int upto);
    bit a;
    for (int i = from; i < upto; i++) begin
      ld_beat(ep, 1'b0, int'(pat(ep, len, i)), a);
      chk(a, "R2", "data beat accepted", a, 1);
    end
  endtask

  task automatic run_in(input int ep, input int mode);
    bit done, pend;
    logic [7:0] pdata;
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = EPW'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
    got_n = 0; done = 0; pend = 0; pdata = '0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      tx_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : (cyc % 5 < 2);
      #1;
      if (pend) chk(tx_valid && tx_data == pdata, "R11", "byte held under stall", int'(tx_data), int'(pdata));
      pend = tx_valid && !tx_ready;
      pdata = tx_data;
      if (tx_valid && tx_ready) begin
        if (got_n == 0) got_d1 = tx_data1;
        if (got_n < 80) got[got_n] = tx_data;
        got_n++;
        if (tx_last) done = 1;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk(done, "R4", "packet ended with tx_last", int'(done), 1);
  endtask

  task automatic expect_pkt(input int ep, input int len, input int nd, input bit good, input string req);
    logic [15:0] c;
    c = crc_of(ep, len, nd);
    if (good) c = ~c;
    chk(got_n == nd + 2, req, "bytes on wire", got_n, nd + 2);
    if (got_n == nd + 2) begin
      for (int i = 0; i < nd; i++)
        chk(got[i] == pat(ep, len, i), req, "data byte", int'(got[i]), int'(pat(ep, len, i)));
      chk(got[nd] == c[7:0], req, "crc low", int'(got[nd]), int'(c[7:0]));
      chk(got[nd+1] == c[15:8], req, "crc high", int'(got[nd+1]), int'(c[15:8]));
    end
    chk(got_d1 == exp_tog[ep], "R8", "data toggle", int'(got_d1), int'(exp_tog[ep]));
  endtask

  task automatic handshake(input int ep, input bit ack, input string req);
    @(negedge clk);
    hs_valid = 1'b1; hs_ack = ack;
    @(negedge clk);
    hs_valid = 1'b0;
    #1;
    chk(done_irq == NEP'(1 << ep), req, "completion pulse", int'(done_irq), 1 << ep);
    chk(done_ack == ack, req, "outcome", int'(done_ack), int'(ack));
    @(negedge clk);
    #1 chk(done_irq == '0, req, "pulse is one cycle", int'(done_irq), 0);
    if (ack) exp_tog[ep] = !exp_tog[ep];
  endtask

  task automatic token_probe(input int ep, input bit exp_nak, input string req);
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = EPW'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
    #1;
    chk(nak_pulse == exp_nak, req, "nak request", int'(nak_pulse), int'(exp_nak));
    chk(!tx_valid, req, "no byte offered", int'(tx_valid), 0);
    @(negedge clk);
    #1 chk(!tx_valid && !nak_pulse, req, "still quiet", int'(tx_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit a;
    for (int e = 0; e < NEP; e++) exp_tog[e] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ld_ep = '0; ld_hdr = 1'b1; ld_data = 8'd5;
    #1;
    // R1: reset state
    chk(!tx_valid, "R1", "tx_valid", int'(tx_valid), 0);
    chk(done_irq == '0 && !nak_pulse, "R1", "pulses idle", int'(done_irq), 0);
    chk(ld_ready, "R1", "endpoint free", int'(ld_ready), 1);

    // R3: token to an empty endpoint
    token_probe(2, 1'b1, "R3");

    // R4, R5, R8, R11: sweep all lengths, endpoints and ready patterns
    for (int len = 0; len <= DEPTH; len++) begin
      int ep;
      ep = len % NEP;
      load_hdr(ep, len);
      write_bytes(ep, len, 0, len);
      run_in(ep, len % 3);
      expect_pkt(ep, len, len, 1'b1, (len == 0) ? "R5" : "R4");
      handshake(ep, 1'b1, "R8");
    end

    // R2: rejected beats
    load_hdr(1, 3);
    write_bytes(1, 3, 0, 3);
    ld_beat(1, 1'b1, 5, a);
    chk(!a, "R2", "count beat to busy endpoint", int'(a), 0);
    ld_beat(1, 1'b0, 8'hEE, a);
    chk(!a, "R2", "data beat beyond count", int'(a), 0);
    ld_beat(0, 1'b1, DEPTH + 1, a);
    chk(!a, "R2", "oversize count", int'(a), 0);
    token_probe(0, 1'b1, "R2");
    run_in(1, 0);
    expect_pkt(1, 3, 3, 1'b1, "R2");

    // R10: tokens while awaiting the handshake are ignored
    token_probe(0, 1'b0, "R10");
    token_probe(1, 1'b0, "R10");

    // R9: timeout keeps packet and toggle
    handshake(1, 1'b0, "R9");
    run_in(1, 2);
    expect_pkt(1, 3, 3, 1'b1, "R9");
    handshake(1, 1'b1, "R9");

    // R10: handshake while idle has no effect
    @(negedge clk);
    hs_valid = 1'b1; hs_ack = 1'b1;
    @(negedge clk);
    hs_valid = 1'b0;
    #1 chk(done_irq == '0, "R10", "stray handshake", int'(done_irq), 0);

    // R7: all endpoints loaded, served out of order
    for (int e = 0; e < NEP; e++) begin
      load_hdr(e, 5 + 3 * e);
      write_bytes(e, 5 + 3 * e, 0, 5 + 3 * e);
    end
    for (int k = 0; k < NEP; k++) begin
      int e;
      e = (k * 3 + 2) % NEP;
      run_in(e, k % 3);
      expect_pkt(e, 5 + 3 * e, 5 + 3 * e, 1'b1, "R7");
      handshake(e, 1'b1, "R7");
    end

    // R6: underrun mid-packet, then retry after the rest is written
    load_hdr(3, 10);
    write_bytes(3, 10, 0, 3);
    run_in(3, 1);
    expect_pkt(3, 10, 3, 1'b0, "R6");
    handshake(3, 1'b0, "R9");
    write_bytes(3, 10, 3, 10);
    run_in(3, 0);
    expect_pkt(3, 10, 10, 1'b1, "R6");
    handshake(3, 1'b1, "R8");

    // R6: underrun with no byte written
    load_hdr(0, 4);
    run_in(0, 0);
    expect_pkt(0, 4, 0, 1'b0, "R6");
    handshake(0, 1'b0, "R9");
    write_bytes(0, 4, 0, 4);
    run_in(0, 2);
    expect_pkt(0, 4, 4, 1'b1, "R6");
    handshake(0, 1'b1, "R8");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule